// File: doc/BRIEF.md
# Contact Smart Card Power and Pin Sequencer

This block is the control core of a contact smart card interface. The host drives the card-side reset, clock, data and two auxiliary lines at all times. The block passes those lines to the card pins only while the card supply is up and reported good. At every other time it holds the card pins low.

Power-up begins when either of two active-low supply-select commands falls, provided a card is seated and the enable input is high. The block then raises an internal supply-enable and keeps the pins low until the supply reports ready. At a fixed checkpoint it aborts the power-up if the supply is still not ready or an overcurrent is present.

Power-down can come from the host releasing both commands or from a hardware event. Either way it removes the card signals in a fixed, timed order and always runs to the end. A sticky flag records whether the last power-down came from a fault. Every control and fault input passes through a two-flop synchronizer before the state machine uses it.

Top module: `card_act_seq`

## Requirements
- R1: After reset, and while idle, all card pins, the reception enable, the supply-enable and the fault flag are low.
- R2: Power-up is accepted on a falling edge of either supply command only while card-present and the enable input are both high; a refused edge leaves the supply-enable low.
- R3: While powered, every card pin stays low until supply-ready has been seen high; from then on each pin follows its host input, and the reception enable is high.
- R4: CHECK_US microseconds after power-up is accepted, the block starts a fault power-down if supply-ready is low; if ready is high it stays powered.
- R5: Releasing both supply commands while powered starts a power-down that leaves the fault flag low.
- R6: Overcurrent, loss of card-present or the off-acknowledge input start a fault power-down at any time while powered; undervoltage does so only after the checkpoint has passed.
- R7: Power-down drops the reset pin first, then the clock, then I/O together with both auxiliary pins and the reception enable, then the supply-enable, each step STEP_US microseconds after the previous one.
- R8: A power-down always completes; command changes during it have no effect, and a new power-up needs both commands to be seen high in idle first.
- R9: The fault flag stays set until the next power-up attempt; when a fault and a host release arrive in the same cycle, the fault wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_a_n | input | 1 | Supply-select command A, active low |
| cmd_b_n | input | 1 | Supply-select command B, active low |
| card_seated | input | 1 | Card present |
| pwr_enable | input | 1 | Power-up permitted when high |
| supply_ok | input | 1 | Card supply ready |
| over_current | input | 1 | Overcurrent fault |
| under_volt | input | 1 | Undervoltage fault |
| off_req | input | 1 | Off-acknowledge, forces power-down |
| host_rst | input | 1 | Host reset line |
| host_clk | input | 1 | Host card clock |
| host_io | input | 1 | Host data line |
| host_aux1 | input | 1 | Host auxiliary line 1 |
| host_aux2 | input | 1 | Host auxiliary line 2 |
| card_rst | output | 1 | Gated card reset |
| card_clk | output | 1 | Gated card clock |
| card_io | output | 1 | Gated card data |
| card_aux1 | output | 1 | Gated auxiliary 1 |
| card_aux2 | output | 1 | Gated auxiliary 2 |
| card_rx_en | output | 1 | Reception mode enable |
| vcc_en | output | 1 | Internal supply-enable |
| fault_off | output | 1 | Last power-down was fault-driven |

## Verification
A host release and a hardware fault can be sampled in the same cycle. The bench provokes this by raising both commands and the off-acknowledge on one clock edge. The power-down must then carry the fault flag, with the normal step order and spacing. A second collision puts the checkpoint expiry, with supply-ready low, against an undervoltage held since early in the ramp: the power-down must be fault-driven, and since the pins were never opened only the supply-enable falls. A scoreboard queue holds the expected pin-fall order and spacing, and a monitor compares each observed fall against it.

// File: rtl/cas_pkg.sv
package cas_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RAMP, ST_LIVE, ST_DOWN} cas_state_e;

  function automatic int unsigned us_to_cyc(int unsigned khz, int unsigned us);
    int unsigned c;
    c = (khz * us) / 1000;
    return (c == 0) ? 1 : c;
  endfunction
endpackage

// File: rtl/cas_sync.sv
module cas_sync #(
  parameter int W = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/cas_timer.sv
module cas_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          done
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/cas_pin_gate.sv
module cas_pin_gate #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] en,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst) q[i] <= 1'b0;
      else     q[i] <= en[i] & d[i];
    end
  end
endmodule

// File: rtl/card_act_seq.sv
module card_act_seq
  import cas_pkg::*;
#(
  parameter int unsigned CLK_KHZ  = 250000,
  parameter int unsigned CHECK_US = 500,
  parameter int unsigned STEP_US  = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic cmd_a_n,
  input  logic cmd_b_n,
  input  logic card_seated,
  input  logic pwr_enable,
  input  logic supply_ok,
  input  logic over_current,
  input  logic under_volt,
  input  logic off_req,
  input  logic host_rst,
  input  logic host_clk,
  input  logic host_io,
  input  logic host_aux1,
  input  logic host_aux2,
  output logic card_rst,
  output logic card_clk,
  output logic card_io,
  output logic card_aux1,
  output logic card_aux2,
  output logic card_rx_en,
  output logic vcc_en,
  output logic fault_off
);
  localparam int unsigned CHECK_CYC = us_to_cyc(CLK_KHZ, CHECK_US);
  localparam int unsigned STEP_CYC  = us_to_cyc(CLK_KHZ, STEP_US);
  localparam int unsigned TMR_MAX   = (CHECK_CYC > STEP_CYC) ? CHECK_CYC : STEP_CYC;
  localparam int TW = $clog2(TMR_MAX + 1);
  localparam int NSYNC = 8;
  localparam int NPIN  = 7;
  localparam logic [1:0] LAST_STAGE = 2'd3;

  // synchronized control inputs
  logic [NSYNC-1:0] raw_in, syn;
  logic a_s, b_s, seat_s, en_s, ok_s, oc_s, uv_s, off_s;

  assign raw_in = {cmd_a_n, cmd_b_n, card_seated, pwr_enable,
                   supply_ok, over_current, under_volt, off_req};

  cas_sync #(.W(NSYNC), .RST_VAL(8'b1100_0000)) u_sync (
    .clk(clk), .rst(rst), .d(raw_in), .q(syn)
  );

  assign {a_s, b_s, seat_s, en_s, ok_s, oc_s, uv_s, off_s} = syn;

  // state
  cas_state_e st_q, st_d;
  logic [1:0] stage_q, stage_d;
  logic arm_q, arm_d, gate_q, gate_d, fault_q, fault_d;
  logic tmr_load, tmr_done;
  logic [TW-1:0] tmr_val;

  logic both_high, act_req, ramp_fault, live_fault;
  assign both_high  = a_s & b_s;
  assign act_req    = (st_q == ST_IDLE) & arm_q & ~both_high;
  assign ramp_fault = oc_s | ~seat_s | off_s;
  assign live_fault = ramp_fault | uv_s;

  cas_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
  );

  always_comb begin
    st_d     = st_q;
    stage_d  = stage_q;
    arm_d    = arm_q;
    gate_d   = gate_q;
    fault_d  = fault_q;
    tmr_load = 1'b0;
    tmr_val  = TW'(STEP_CYC - 1);
    case (st_q)
      ST_IDLE: begin
        gate_d  = 1'b0;
        stage_d = '0;
        if (both_high) arm_d = 1'b1;
        if (act_req) begin
          arm_d   = 1'b0;
          fault_d = 1'b0;
          if (seat_s && en_s) begin
            st_d     = ST_RAMP;
            tmr_load = 1'b1;
            tmr_val  = TW'(CHECK_CYC - 1);
          end
        end
      end
      ST_RAMP: begin
        if (ok_s) gate_d = 1'b1;
        if (ramp_fault || (tmr_done && !ok_s)) begin
          st_d     = ST_DOWN;
          fault_d  = 1'b1;
          tmr_load = 1'b1;
        end else if (both_high) begin
          st_d     = ST_DOWN;
          tmr_load = 1'b1;
        end else if (tmr_done) begin
          st_d = ST_LIVE;
        end
      end
      ST_LIVE: begin
        if (live_fault) begin
          st_d     = ST_DOWN;
          fault_d  = 1'b1;
          tmr_load = 1'b1;
        end else if (both_high) begin
          st_d     = ST_DOWN;
          tmr_load = 1'b1;
        end
      end
      default: begin
        if (tmr_done) begin
          if (stage_q == LAST_STAGE) begin
            st_d = ST_IDLE;
          end else begin
            stage_d  = stage_q + 2'd1;
            tmr_load = 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      stage_q <= '0;
      arm_q   <= 1'b0;
      gate_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      stage_q <= stage_d;
      arm_q   <= arm_d;
      gate_q  <= gate_d;
      fault_q <= fault_d;
    end
  end

  // pin enables per teardown stage
  logic powered, up_phase, en_r, en_c, en_d;
  assign powered  = (st_q != ST_IDLE);
  assign up_phase = (st_q == ST_RAMP) | (st_q == ST_LIVE);
  assign en_r = gate_q & (up_phase | ((st_q == ST_DOWN) & (stage_q == 2'd0)));
  assign en_c = gate_q & (up_phase | ((st_q == ST_DOWN) & (stage_q <= 2'd1)));
  assign en_d = gate_q & (up_phase | ((st_q == ST_DOWN) & (stage_q <= 2'd2)));

  logic [NPIN-1:0] pin_en, pin_d, pin_q;
  assign pin_en = {powered, en_d, en_d, en_d, en_d, en_c, en_r};
  assign pin_d  = {1'b1, 1'b1, host_aux2, host_aux1, host_io, host_clk, host_rst};

  cas_pin_gate #(.N(NPIN)) u_pins (
    .clk(clk), .rst(rst), .en(pin_en), .d(pin_d), .q(pin_q)
  );

  assign {vcc_en, card_rx_en, card_aux2, card_aux1, card_io, card_clk, card_rst} = pin_q;
  assign fault_off = fault_q;

  // checks next to the logic
  assert_idle_low_R1: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE && $past(st_q) == ST_IDLE) |->
      !(card_rst | card_clk | card_io | card_aux1 | card_aux2 | card_rx_en | vcc_en));

  assert_pins_wait_ready_R3: assert property (@(posedge clk) disable iff (rst)
    !gate_q |=> !(card_rst | card_clk | card_io | card_aux1 | card_aux2 | card_rx_en));

  assert_checkpoint_abort_R4: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RAMP && tmr_done && !ok_s) |=> (st_q == ST_DOWN && fault_q));

  assert_supply_last_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(vcc_en) |-> !(card_rst | card_clk | card_io | card_aux1 | card_aux2 | card_rx_en));

  assert_down_completes_R8: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_DOWN) |=> (st_q == ST_DOWN || st_q == ST_IDLE));

  assert_fault_on_entry_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(fault_q) |-> (st_q == ST_DOWN));
endmodule

// File: tb/tb_card_act_seq.sv
module tb_card_act_seq;
  localparam int STEP = 50;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_a_n = 1'b1, cmd_b_n = 1'b1, card_seated = 1'b0, pwr_enable = 1'b1;
  logic supply_ok = 1'b0, over_current = 1'b0, under_volt = 1'b0, off_req = 1'b0;
  logic host_rst = 1'b1, host_clk = 1'b1, host_io = 1'b1, host_aux1 = 1'b1, host_aux2 = 1'b1;
  logic card_rst, card_clk, card_io, card_aux1, card_aux2, card_rx_en, vcc_en, fault_off;

  always #2 clk = ~clk;

  card_act_seq #(.CLK_KHZ(1000), .CHECK_US(500), .STEP_US(STEP)) dut (
    .clk(clk), .rst(rst), .cmd_a_n(cmd_a_n), .cmd_b_n(cmd_b_n),
    .card_seated(card_seated), .pwr_enable(pwr_enable), .supply_ok(supply_ok),
    .over_current(over_current), .under_volt(under_volt), .off_req(off_req),
    .host_rst(host_rst), .host_clk(host_clk), .host_io(host_io),
    .host_aux1(host_aux1), .host_aux2(host_aux2),
    .card_rst(card_rst), .card_clk(card_clk), .card_io(card_io),
    .card_aux1(card_aux1), .card_aux2(card_aux2), .card_rx_en(card_rx_en),
    .vcc_en(vcc_en), .fault_off(fault_off)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit done = 1'b0;
  bit mon_on = 1'b0;
  string exp_name[$];
  int    exp_gap[$];
  int    last_cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver side of the scoreboard: push the expected fall order
  task automatic expect_teardown(input bit pins_open);
    if (pins_open) begin
      exp_name.push_back("rst"); exp_gap.push_back(-1);
      exp_name.push_back("clk"); exp_gap.push_back(STEP);
      exp_name.push_back("io");  exp_gap.push_back(STEP);
      exp_name.push_back("vcc"); exp_gap.push_back(STEP);
    end else begin
      exp_name.push_back("vcc"); exp_gap.push_back(-1);
    end
    mon_on = 1'b1;
  endtask

  task automatic note_fall(input string nm);
    string en; int eg;
    if (exp_name.size() == 0) begin
      chk(1'b0, "R7", {"unexpected fall of ", nm}, cyc, -1);
    end else begin
      en = exp_name.pop_front();
      eg = exp_gap.pop_front();
      chk(en == nm, "R7", {"fall order, got ", nm, " wanted ", en}, 0, 1);
      if (eg >= 0) chk(cyc - last_cyc == eg, "R7", {"step spacing before ", nm}, cyc - last_cyc, eg);
      if (nm == "io")
        chk(!(card_aux1 | card_aux2 | card_rx_en), "R7", "aux/rx drop with io",
            int'({card_aux1, card_aux2, card_rx_en}), 0);
    end
    last_cyc = cyc;
  endtask

  // monitor side of the scoreboard
  logic p_rst = 0, p_clk = 0, p_io = 0, p_vcc = 0;
  always @(negedge clk) begin
    if (mon_on) begin
      if (p_rst && !card_rst) note_fall("rst");
      if (p_clk && !card_clk) note_fall("clk");
      if (p_io  && !card_io)  note_fall("io");
      if (p_vcc && !vcc_en)   note_fall("vcc");
    end
    p_rst <= card_rst; p_clk <= card_clk; p_io <= card_io; p_vcc <= vcc_en;
  end

  task automatic finish_teardown(input string req);
    chk(exp_name.size() == 0, req, "teardown events left", exp_name.size(), 0);
    mon_on = 1'b0;
    exp_name.delete(); exp_gap.delete();
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R8 watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    wait_cyc(5);
    rst = 1'b0;
    wait_cyc(1);
    chk(!(card_rst | card_clk | card_io | card_aux1 | card_aux2 | card_rx_en | vcc_en | fault_off),
        "R1", "outputs after reset", int'({card_rst, card_clk, card_io, vcc_en, fault_off}), 0);
    wait_cyc(5);

    // R2: refused without card
    cmd_a_n = 1'b0; wait_cyc(20);
    chk(vcc_en == 0, "R2", "no card: supply stays off", vcc_en, 0);
    card_seated = 1'b1; wait_cyc(20);
    chk(vcc_en == 0, "R8", "command still low: no re-arm", vcc_en, 0);
    cmd_a_n = 1'b1; wait_cyc(6);
    // R2: refused with enable low
    pwr_enable = 1'b0; wait_cyc(4);
    cmd_b_n = 1'b0; wait_cyc(20);
    chk(vcc_en == 0, "R2", "enable low: supply stays off", vcc_en, 0);
    cmd_b_n = 1'b1; pwr_enable = 1'b1; wait_cyc(6);

    // R2/R3: accepted, pins held low before ready
    cmd_a_n = 1'b0; wait_cyc(20);
    chk(vcc_en == 1, "R2", "accepted power-up", vcc_en, 1);
    chk(!(card_rst | card_clk | card_io | card_aux1 | card_aux2 | card_rx_en), "R3",
        "pins low before ready", int'({card_rst, card_clk, card_io, card_aux1, card_aux2}), 0);
    supply_ok = 1'b1; wait_cyc(10);
    chk(card_rst & card_clk & card_io & card_aux1 & card_aux2 & card_rx_en, "R3",
        "pins follow host after ready", int'({card_rst, card_clk, card_io, card_aux1, card_aux2}), 31);
    host_rst = 1'b0; host_aux2 = 1'b0; wait_cyc(3);
    chk(card_rst == 0 && card_aux2 == 0, "R3", "pins track host low", int'({card_rst, card_aux2}), 0);
    host_rst = 1'b1; host_aux2 = 1'b1; wait_cyc(600);
    chk(vcc_en == 1, "R4", "ready at checkpoint keeps power", vcc_en, 1);

    // R5/R7/R8: host release, with a command glitch during teardown
    expect_teardown(1'b1);
    cmd_a_n = 1'b1; wait_cyc(20);
    cmd_b_n = 1'b0; wait_cyc(300);
    finish_teardown("R8");
    chk(fault_off == 0, "R5", "host release is not a fault", fault_off, 0);
    chk(vcc_en == 0, "R8", "no power-up without re-arm", vcc_en, 0);
    cmd_b_n = 1'b1; wait_cyc(6);

    // R4: checkpoint abort with supply never ready
    supply_ok = 1'b0;
    cmd_a_n = 1'b0; wait_cyc(450);
    chk(vcc_en == 1, "R4", "still powered before checkpoint", vcc_en, 1);
    expect_teardown(1'b0);
    wait_cyc(350);
    finish_teardown("R4");
    chk(fault_off == 1, "R4", "checkpoint abort is a fault", fault_off, 1);
    chk(card_rst == 0 && card_io == 0, "R3", "pins never opened", int'({card_rst, card_io}), 0);
    cmd_a_n = 1'b1; wait_cyc(10);
    chk(fault_off == 1, "R9", "flag held until next attempt", fault_off, 1);
    supply_ok = 1'b1;
    cmd_a_n = 1'b0; wait_cyc(8);
    chk(fault_off == 0, "R9", "flag cleared by new attempt", fault_off, 0);

    // R6: overcurrent while live
    wait_cyc(600);
    expect_teardown(1'b1);
    over_current = 1'b1; wait_cyc(260);
    finish_teardown("R6");
    chk(fault_off == 1, "R6", "overcurrent fault flag", fault_off, 1);
    over_current = 1'b0; cmd_a_n = 1'b1; wait_cyc(6);

    // R6: card removal while live
    cmd_a_n = 1'b0; wait_cyc(600);
    expect_teardown(1'b1);
    card_seated = 1'b0; wait_cyc(260);
    finish_teardown("R6");
    chk(fault_off == 1, "R6", "card removal fault flag", fault_off, 1);
    card_seated = 1'b1; cmd_a_n = 1'b1; wait_cyc(6);

    // R6: undervoltage ignored during ramp, acted on after checkpoint
    cmd_b_n = 1'b0; wait_cyc(100);
    under_volt = 1'b1; wait_cyc(300);
    chk(vcc_en == 1, "R6", "undervoltage ignored in ramp", vcc_en, 1);
    expect_teardown(1'b1);
    wait_cyc(400);
    finish_teardown("R6");
    chk(fault_off == 1, "R6", "undervoltage fault after checkpoint", fault_off, 1);
    under_volt = 1'b0; cmd_b_n = 1'b1; wait_cyc(6);

    // R9: host release and off-acknowledge on the same edge
    cmd_a_n = 1'b0; wait_cyc(600);
    chk(vcc_en == 1, "R9", "live before collision", vcc_en, 1);
    expect_teardown(1'b1);
    cmd_a_n = 1'b1; off_req = 1'b1; wait_cyc(260);
    finish_teardown("R9");
    chk(fault_off == 1, "R9", "fault wins over host release", fault_off, 1);
    off_req = 1'b0; wait_cyc(6);

    // R9: checkpoint expiry with ready low against undervoltage held through the ramp
    supply_ok = 1'b0;
    cmd_b_n = 1'b0; wait_cyc(100);
    under_volt = 1'b1; wait_cyc(300);
    chk(vcc_en == 1, "R9", "powered before checkpoint collision", vcc_en, 1);
    expect_teardown(1'b0);
    wait_cyc(400);
    finish_teardown("R9");
    chk(fault_off == 1, "R9", "checkpoint collision is a fault", fault_off, 1);
    chk(card_rst == 0 && card_io == 0, "R3", "pins closed after collision", int'({card_rst, card_io}), 0);
    under_volt = 1'b0; supply_ok = 1'b1; cmd_b_n = 1'b1;
    wait_cyc(20);
    chk(vcc_en == 0, "R1", "idle supply off at end", vcc_en, 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule